// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs the shift and rotate group of a processor's integer datapath. It takes the 16-bit operation word of a shift or rotate instruction, the low six bits of a count register, a 32-bit operand and the incoming extend flag. It returns the shifted operand and the five condition flags one clock later. Four operation classes are decoded from the operation word: arithmetic shift, logical shift, rotate through the extend bit, and plain rotate. Each class works in either direction on byte, word or long operands.

The count comes from one of three sources. It can be a 3-bit immediate held in the operation word, the low bits of a data register, or a fixed count of one for the memory form, which always works on a word. Only the low byte, low word or whole long word of the operand takes part in the operation. The remaining upper bits come back unchanged, so the result can be written straight back to a register. Memory access and register-file reads are handled outside this unit.

Top module: `shiftrot_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted operation, `out_valid`, `result` and all five flags are 0.
- R2: An operation presented with `in_valid` high appears on the outputs at the next rising clock edge, with `out_valid` high for that one cycle. When `in_valid` is low, `result` and the flags hold their previous values and `out_valid` is low.
- R3: Register form: `op_word[7:6]` is not 11. `op_word[8]` is the direction (1 = left), `op_word[7:6]` the size (00 byte, 01 word, 10 long), `op_word[4:3]` the class (00 arithmetic, 01 logical, 10 rotate through extend, 11 plain rotate), and `op_word[5]` the count source. When `op_word[5]` is 1 the count is `count_reg` (0 to 63). When it is 0 the count is `op_word[11:9]`, where 000 stands for 8.
- R4: Memory form: `op_word[7:6]` is 11. The class is `op_word[10:9]`, the direction is `op_word[8]`, the size is word and the count is exactly 1.
- R5: Only the low 8, 16 or 32 bits of `operand` are shifted. `result` bits above the selected size equal the matching `operand` bits.
- R6: A logical shift fills vacated bits with 0. C is the last bit shifted out and X takes the same value, and V is 0.
- R7: A right arithmetic shift copies the sign bit into vacated bits and never sets V. A left arithmetic shift fills with 0 and sets V when the most significant bit of the field changes at any step of the shift.
- R8: A plain rotate leaves X equal to `x_in`, clears V, and sets C to the last bit carried around the loop.
- R9: A rotate through extend treats X as one extra bit of the loop. X enters the vacated bit, X takes the bit shifted out, and C equals the final X. V is 0.
- R10: With a count of zero the field is unchanged, X equals `x_in` and V is 0. C is 0, except for rotate through extend, where C equals `x_in`.
- R11: N is the most significant bit of the result field for the selected size, and Z is 1 exactly when that field is all zeros.
- R12: A shift count at or beyond the field width shifts the whole field out. A logical shift gives 0 with C = 0 when the count exceeds the width. A right arithmetic shift gives all sign bits with C equal to the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_word | input | 16 | Shift or rotate operation word |
| count_reg | input | 6 | Low six bits of the count register |
| operand | input | 32 | Value to shift or rotate |
| x_in | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result and flags updated this cycle |
| result | output | 32 | Shifted operand with untouched upper bits |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Several rules are checked by the assertions on every cycle. These are the one-cycle handshake and the holding of outputs while idle, the V flag staying clear for logical shifts, plain rotates and right arithmetic shifts, a plain rotate passing X through, upper bits surviving a byte operation, and Z excluding N. The bench scenarios cover the rest: exact result values, the bit chosen for C, an overflow that appears only partway through a long left arithmetic shift, the immediate value that stands for eight, register counts beyond the field width, and rotates through extend whose count is a multiple of the loop length.

// File: rtl/shiftrot_pkg.sv
package shiftrot_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned CNT_W  = 6;
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_MEM  = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        K_ASH = 2'b00,
        K_LSH = 2'b01,
        K_ROX = 2'b10,
        K_ROT = 2'b11
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             left;
        size_e            size;
        logic [CNT_W-1:0] count;
    } ctl_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              x;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
    } out_t;

endpackage

// File: rtl/shiftrot_decode.sv
module shiftrot_decode
    import shiftrot_pkg::*;
(
    input  logic [15:0]      op_word,
    input  logic [CNT_W-1:0] count_reg,
    output ctl_t             ctl
);

    logic mem_form;

    assign mem_form = (op_word[7:6] == 2'b11);

    always_comb begin
        ctl.left = op_word[8];
        if (mem_form) begin
            // memory form: word operand, single step, class sits higher up
            ctl.kind  = kind_e'(op_word[10:9]);
            ctl.size  = SZ_WORD;
            ctl.count = CNT_W'(1);
        end else begin
            ctl.kind = kind_e'(op_word[4:3]);
            ctl.size = size_e'(op_word[7:6]);
            if (op_word[5]) begin
                ctl.count = count_reg;
            end else if (op_word[11:9] == 3'd0) begin
                ctl.count = CNT_W'(8);
            end else begin
                ctl.count = CNT_W'(op_word[11:9]);
            end
        end
    end

endmodule

// File: rtl/shiftrot_core.sv
module shiftrot_core
    import shiftrot_pkg::*;
(
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] operand,
    input  logic              x_in,
    output logic [DATA_W-1:0] field,
    output logic [DATA_W-1:0] mask,
    output logic [IDX_W-1:0]  msb,
    output logic              x_o,
    output logic              v_o,
    output logic              c_o
);

    localparam int unsigned STEPS = (1 << CNT_W) - 1;

    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] nxt;
    logic              sh_out;
    logic              fill;

    always_comb begin
        mask = '0;
        unique case (ctl.size)
            SZ_BYTE: begin
                msb       = IDX_W'(7);
                mask[7:0] = '1;
            end
            SZ_WORD: begin
                msb        = IDX_W'(15);
                mask[15:0] = '1;
            end
            default: begin
                msb  = IDX_W'(DATA_W - 1);
                mask = '1;
            end
        endcase
    end

    always_comb begin
        val    = operand & mask;
        x_o    = x_in;
        v_o    = 1'b0;
        c_o    = (ctl.kind == K_ROX) ? x_in : 1'b0;
        nxt    = '0;
        sh_out = 1'b0;
        fill   = 1'b0;
        for (int i = 0; i < STEPS; i++) begin
            if (i < int'(ctl.count)) begin
                if (ctl.left) begin
                    sh_out = val[msb];
                    unique case (ctl.kind)
                        K_ROT:   fill = sh_out;
                        K_ROX:   fill = x_o;
                        default: fill = 1'b0;
                    endcase
                    nxt    = (val << 1) & mask;
                    nxt[0] = fill;
                    if (ctl.kind == K_ASH && nxt[msb] != val[msb]) begin
                        v_o = 1'b1;
                    end
                end else begin
                    sh_out = val[0];
                    unique case (ctl.kind)
                        K_ASH:   fill = val[msb];
                        K_ROT:   fill = sh_out;
                        K_ROX:   fill = x_o;
                        default: fill = 1'b0;
                    endcase
                    nxt      = val >> 1;
                    nxt[msb] = fill;
                end
                val = nxt;
                c_o = sh_out;
                if (ctl.kind != K_ROT) begin
                    x_o = sh_out;
                end
            end
        end
        field = val;
    end

endmodule

// File: rtl/shiftrot_merge.sv
module shiftrot_merge
    import shiftrot_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] field,
    input  logic [DATA_W-1:0] mask,
    input  logic [IDX_W-1:0]  msb,
    output logic [DATA_W-1:0] result,
    output logic              n_o,
    output logic              z_o
);

    always_comb begin
        result = (operand & ~mask) | (field & mask);
        n_o    = field[msb];
        z_o    = ((field & mask) == '0);
    end

endmodule

// File: rtl/shiftrot_unit.sv
module shiftrot_unit
    import shiftrot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       op_word,
    input  logic [CNT_W-1:0]  count_reg,
    input  logic [DATA_W-1:0] operand,
    input  logic              x_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              flag_x,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);

    ctl_t              ctl;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] mask;
    logic [IDX_W-1:0]  msb;
    logic              x_c;
    logic              v_c;
    logic              c_c;
    logic [DATA_W-1:0] merged;
    logic              n_c;
    logic              z_c;
    out_t              st_d;
    out_t              st_q;

    shiftrot_decode u_dec (
        .op_word   (op_word),
        .count_reg (count_reg),
        .ctl       (ctl)
    );

    shiftrot_core u_core (
        .ctl     (ctl),
        .operand (operand),
        .x_in    (x_in),
        .field   (field),
        .mask    (mask),
        .msb     (msb),
        .x_o     (x_c),
        .v_o     (v_c),
        .c_o     (c_c)
    );

    shiftrot_merge u_merge (
        .operand (operand),
        .field   (field),
        .mask    (mask),
        .msb     (msb),
        .result  (merged),
        .n_o     (n_c),
        .z_o     (z_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = merged;
            st_d.x      = x_c;
            st_d.n      = n_c;
            st_d.z      = z_c;
            st_d.v      = v_c;
            st_d.c      = c_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign flag_x    = st_q.x;
    assign flag_n    = st_q.n;
    assign flag_z    = st_q.z;
    assign flag_v    = st_q.v;
    assign flag_c    = st_q.c;

endmodule

// File: rtl/shiftrot_chk.sv
module shiftrot_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] op_word,
    input logic [31:0] operand,
    input logic        x_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag_x,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v
);

    logic       is_mem;
    logic [1:0] cls;

    assign is_mem = (op_word[7:6] == 2'b11);
    assign cls    = is_mem ? op_word[10:9] : op_word[4:3];

    // R2: accepted operation shows up one cycle later
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle cycles keep the registered outputs
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_x)
                       && $stable(flag_v)));

    // R6: logical shifts never report overflow
    p_lsh_nov_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'b01) |=> !flag_v);

    // R7: right arithmetic shift never reports overflow
    p_asr_nov_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'b00 && !op_word[8]) |=> !flag_v);

    // R8: plain rotate passes X through and clears V
    p_rot_keepx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'b11) |=> (flag_x == $past(x_in) && !flag_v));

    // R9: rotate through extend clears V
    p_rox_nov_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'b10) |=> !flag_v);

    // R5: byte operations keep bits 31..8 of the operand
    p_upper_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_word[7:6] == 2'b00) |=> result[31:8] == $past(operand[31:8]));

    // R11: a zero field cannot be negative
    p_zero_not_neg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_z) |-> !flag_n);

endmodule

bind shiftrot_unit shiftrot_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_word   (op_word),
    .operand   (operand),
    .x_in      (x_in),
    .out_valid (out_valid),
    .result    (result),
    .flag_x    (flag_x),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v)
);

// File: tb/sim_shiftrot_unit.sv
`timescale 1ns/1ps
module sim_shiftrot_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] op_word;
    logic [5:0]  count_reg;
    logic [31:0] operand;
    logic        x_in;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;

    always #2 clk = ~clk;

    shiftrot_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_word   (op_word),
        .count_reg (count_reg),
        .operand   (operand),
        .x_in      (x_in),
        .out_valid (out_valid),
        .result    (result),
        .flag_x    (flag_x),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c)
    );

    typedef struct {
        logic [31:0] res;
        logic [4:0]  flags;   // x n z v c
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   vectors     = 0;
    int   miscompares = 0;
    bit   done        = 1'b0;
    logic [31:0] last_res;

    function automatic logic [15:0] regop(input logic [2:0] cnt, input logic left,
                                          input logic [1:0] sz, input logic use_reg,
                                          input logic [1:0] tt);
        return {4'b1110, cnt, left, sz, use_reg, tt, 3'b010};
    endfunction

    function automatic logic [15:0] memop(input logic [1:0] tt, input logic left);
        return {4'b1110, 1'b0, tt, left, 2'b11, 6'b010001};
    endfunction

    // Reference computed from the requirements in closed form
    function automatic exp_t model(input logic [15:0] op, input logic [5:0] creg,
                                   input logic [31:0] opd, input logic xin);
        exp_t e;
        logic [1:0]  tt;
        logic        left;
        int          w, n, k;
        logic [63:0] m, fv, r, se, ext, m1, re;
        logic        c, x, vf, sign, bk;
        if (op[7:6] == 2'b11) begin
            tt = op[10:9]; left = op[8]; w = 16; n = 1;
        end else begin
            tt = op[4:3]; left = op[8];
            w = (op[7:6] == 2'b00) ? 8 : (op[7:6] == 2'b01) ? 16 : 32;
            if (op[5]) n = int'(creg);
            else n = (op[11:9] == 3'd0) ? 8 : int'(op[11:9]);
        end
        m    = (64'd1 << w) - 64'd1;
        fv   = {32'd0, opd} & m;
        sign = fv[w-1];
        vf   = 1'b0;
        x    = xin;
        c    = 1'b0;
        r    = fv;
        case (tt)
            2'b00, 2'b01: begin
                if (left) begin
                    r = (fv << n) & m;
                    c = (n == 0) ? 1'b0 : (n <= w) ? fv[w-n] : 1'b0;
                    if (tt == 2'b00) begin
                        for (int s = 1; s <= n; s++) begin
                            bk = (w - 1 - s >= 0) ? fv[w-1-s] : 1'b0;
                            if (bk != sign) vf = 1'b1;
                        end
                    end
                end else if (tt == 2'b01) begin
                    r = fv >> n;
                    c = (n == 0) ? 1'b0 : (n <= w) ? fv[n-1] : 1'b0;
                end else begin
                    se = sign ? (fv | ~m) : fv;
                    r  = 64'($signed(se) >>> n) & m;
                    c  = (n == 0) ? 1'b0 : (n <= w) ? fv[n-1] : sign;
                end
                x = (n == 0) ? xin : c;
            end
            2'b11: begin
                k = n % w;
                if (left) r = ((fv << k) | (fv >> (w - k))) & m;
                else      r = ((fv >> k) | (fv << (w - k))) & m;
                c = (n == 0) ? 1'b0 : (left ? r[0] : r[w-1]);
            end
            default: begin
                ext = fv | ({63'd0, xin} << w);
                m1  = (64'd1 << (w + 1)) - 64'd1;
                k   = n % (w + 1);
                if (left) re = ((ext << k) | (ext >> (w + 1 - k))) & m1;
                else      re = ((ext >> k) | (ext << (w + 1 - k))) & m1;
                r = re & m;
                x = re[w];
                c = x;
            end
        endcase
        e.res   = (opd & ~m[31:0]) | r[31:0];
        e.flags = {x, r[w-1], (r == 64'd0), vf, c};
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic apply(input logic [15:0] op, input logic [5:0] creg,
                         input logic [31:0] opd, input logic xin, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        op_word   = op;
        count_reg = creg;
        operand   = opd;
        x_in      = xin;
        e         = model(op, creg, opd, xin);
        e.tag     = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each registered result against the queued expectation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", 64'(result), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(result == e.res && {flag_x, flag_n, flag_z, flag_v, flag_c} == e.flags,
                      e.tag,
                      {27'd0, flag_x, flag_n, flag_z, flag_v, flag_c, result},
                      {27'd0, e.flags, e.res});
                last_res = result;
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_word = '0; count_reg = '0;
        operand = '0; x_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!out_valid && result == 32'd0
              && {flag_x, flag_n, flag_z, flag_v, flag_c} == 5'd0,
              "R1 reset state", {31'd0, out_valid, result}, 64'd0);

        apply(regop(3'd3, 1'b1, 2'b00, 1'b0, 2'b01), 6'd0, 32'h1234_56F1, 1'b0, "R6 LSL byte by 3");
        apply(regop(3'd0, 1'b0, 2'b10, 1'b1, 2'b01), 6'd5, 32'h8000_0031, 1'b1, "R6 LSR long by reg 5");
        apply(regop(3'd0, 1'b1, 2'b01, 1'b0, 2'b01), 6'd0, 32'hAAAA_8181, 1'b0, "R3 imm 000 means 8");
        apply(regop(3'd5, 1'b1, 2'b01, 1'b1, 2'b01), 6'd2, 32'h0000_4003, 1'b0, "R3 register count 2");
        apply(regop(3'd3, 1'b0, 2'b00, 1'b0, 2'b00), 6'd0, 32'hFFFF_FF80, 1'b0, "R7 ASR byte sign fill");
        apply(regop(3'd1, 1'b1, 2'b00, 1'b0, 2'b00), 6'd0, 32'h0000_0040, 1'b0, "R7 ASL byte V first step");
        apply(regop(3'd3, 1'b1, 2'b00, 1'b0, 2'b00), 6'd0, 32'h0000_0020, 1'b0, "R7 ASL byte V mid shift");
        apply(regop(3'd2, 1'b1, 2'b00, 1'b0, 2'b00), 6'd0, 32'h0000_00FF, 1'b0, "R7 ASL byte no V");
        apply(regop(3'd0, 1'b1, 2'b10, 1'b1, 2'b00), 6'd40, 32'h0000_0001, 1'b0, "R7 ASL long by 40");
        apply(regop(3'd4, 1'b1, 2'b01, 1'b0, 2'b11), 6'd0, 32'h5555_9ABC, 1'b1, "R8 ROL word by 4");
        apply(regop(3'd0, 1'b0, 2'b10, 1'b1, 2'b11), 6'd33, 32'h0000_0003, 1'b0, "R8 ROR long by 33");
        apply(regop(3'd1, 1'b1, 2'b00, 1'b0, 2'b10), 6'd0, 32'h0000_0080, 1'b1, "R9 ROXL byte by 1");
        apply(regop(3'd0, 1'b0, 2'b01, 1'b1, 2'b10), 6'd17, 32'h0000_1234, 1'b1, "R9 ROXR word by 17");
        apply(regop(3'd0, 1'b0, 2'b01, 1'b1, 2'b10), 6'd5, 32'h0000_0013, 1'b0, "R9 ROXR word by 5");
        apply(regop(3'd0, 1'b1, 2'b10, 1'b1, 2'b01), 6'd0, 32'h8000_0000, 1'b1, "R10 LSL zero count");
        apply(regop(3'd0, 1'b1, 2'b00, 1'b1, 2'b10), 6'd0, 32'h0000_0001, 1'b1, "R10 ROXL zero count");
        apply(regop(3'd0, 1'b0, 2'b10, 1'b1, 2'b11), 6'd0, 32'h8000_0001, 1'b0, "R10 ROR zero count");
        apply(memop(2'b00, 1'b1), 6'd9, 32'hABCD_4000, 1'b0, "R4 memory ASL word by 1");
        apply(memop(2'b11, 1'b0), 6'd9, 32'h1111_0001, 1'b0, "R4 memory ROR word by 1");
        apply(regop(3'd0, 1'b0, 2'b10, 1'b1, 2'b01), 6'd40, 32'hFFFF_FFFF, 1'b0, "R12 LSR long by 40");
        apply(regop(3'd0, 1'b0, 2'b10, 1'b1, 2'b00), 6'd50, 32'h8000_0000, 1'b0, "R12 ASR long by 50");
        apply(regop(3'd0, 1'b0, 2'b00, 1'b0, 2'b01), 6'd0, 32'hCAFE_00FF, 1'b0, "R11 Z on byte field");
        apply(regop(3'd1, 1'b0, 2'b01, 1'b0, 2'b11), 6'd0, 32'h0000_0001, 1'b0, "R11 N on word field");
        apply(regop(3'd2, 1'b1, 2'b00, 1'b0, 2'b01), 6'd0, 32'hDEAD_BE3F, 1'b0, "R5 upper bits kept");

        // R2: idle cycle with changed inputs must not disturb outputs
        @(negedge clk);
        in_valid = 1'b0;
        op_word  = regop(3'd7, 1'b1, 2'b10, 1'b0, 2'b01);
        operand  = 32'h1357_9BDF;
        @(negedge clk);
        @(negedge clk);
        check(!out_valid && result == last_res, "R2 hold while idle",
              {31'd0, out_valid, result}, {32'd0, last_res});
        check(exp_q.size() == 0, "R2 every vector answered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule